// File: doc/BRIEF.md
# Bus Target Write-Path Controller

This block sits behind a simplified PCI-style target port. It watches address phases, which carry an address and a four-bit command code, and the data phases that follow them. Each data phase carries a data word, byte enables and a final-phase flag. The address is matched against six base address windows. The command is sorted into memory write, memory read, I/O read, I/O write or unsupported. The block then answers each data phase with one of three responses: accept, retry or disconnect.

Accepted memory writes go into a receive FIFO. Each entry holds the phase address, the data word, the byte enables and the index of the window that was hit. A downstream consumer drains the FIFO through a pop handshake. Memory reads are not serviced here. They are retried, and a one-cycle hand-off request is raised for a separate delayed-read unit. I/O cycles aimed at window 4 reach a small bank of 32-bit registers. A test-mode input decides which of those registers may be written.

Top module: `tgt_wr_ctrl`

## Requirements
- R1: A memory write is accepted only when the address hits window 0, 1, 2 or 3 and the command is 4'h7 (memory write) or 4'hF (memory write and invalidate). When several windows match, the lowest index wins. Response codes are 2'b00 none, 2'b01 accept, 2'b10 retry and 2'b11 disconnect.
- R2: Each accepted write phase pushes one FIFO entry holding the phase address, data, byte enables and the hit window index (3 bits, 0 to 5). The first phase uses the address-phase address, and each following phase adds 4. Entries leave in arrival order, and the head entry holds steady until it is popped.
- R3: If the FIFO is full on the first data phase of a memory write, that phase gets retry, nothing is pushed and the transaction ends.
- R4: If the FIFO is full on a later data phase of a memory write, that phase gets disconnect, nothing is pushed and the transaction ends. Further data phases get no response.
- R5: Every byte-enable pattern, including 4'b0000, is accepted on write phases and stored unchanged.
- R6: An I/O read (4'h2) or I/O write (4'h3) that hits window 4 accepts its first data phase. A second data phase gets disconnect, which ends the transaction, and it is not applied to any register.
- R7: The register bank holds NREG words at word offsets taken from address bits [2+:log2 NREG] within window 4. Offsets DB0_IDX (default 0) and DB1_IDX (default 1) are the doorbells.
  - With test_mode = 0, only the doorbells accept writes.
  - With test_mode = 1, every register accepts writes.
  - Writes apply their byte enables.
  - A denied write is dropped without any error response.
  - io_rdata always shows the addressed register.
- R8: A memory read (4'h6, 4'hC or 4'hE) that hits any window raises rd_req for the single cycle after its address phase, together with the address and window index. Its data phase gets retry.
- R9: An address that hits no window, or a command that is unsupported for the window hit, draws no response on any data phase and pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Address phase strobe |
| addr_in | input | AW | Address of the transaction |
| cmd_in | input | 4 | Command code |
| data_valid | input | 1 | Data phase strobe |
| data_in | input | 32 | Write data of the phase |
| data_be | input | 4 | Byte enables of the phase |
| data_last | input | 1 | Initiator marks the final data phase |
| test_mode | input | 1 | 1 opens every register to writes |
| bar_bases | input | 6*AW | Window base addresses, window k at bits [k*AW +: AW] |
| resp | output | 2 | Response to the current data phase |
| rd_req | output | 1 | Delayed-read hand-off pulse |
| rd_req_addr | output | AW | Address of the handed-off read |
| rd_req_bar | output | 3 | Window index of the handed-off read |
| io_rdata | output | 32 | Register addressed by the current transaction |
| rx_pop | input | 1 | Consumer removes the FIFO head |
| rx_valid | output | 1 | FIFO holds at least one entry |
| rx_addr | output | AW | Head entry address |
| rx_data | output | 32 | Head entry data |
| rx_be | output | 4 | Head entry byte enables |
| rx_bar | output | 3 | Head entry window index |

## Verification
The bench builds the block with FIFO_DEPTH = 4, WIN_LOG2 = 12 and NREG = 8. With those values a five-phase burst into an empty FIFO fills it on the fourth phase and is disconnected on the fifth, and a following burst meets a full FIFO on its first phase and is retried. That puts both flow-control responses within a few cycles of each other. The eight registers include offset 2, which is not a doorbell, so the permission rule can be exercised under both test-mode settings. The 4 KB windows, spaced 1 MB apart, leave clear gaps for miss addresses.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
    typedef enum logic [1:0] {
        RSP_NONE   = 2'b00,
        RSP_ACCEPT = 2'b01,
        RSP_RETRY  = 2'b10,
        RSP_DISC   = 2'b11
    } resp_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEMW,
        ST_IOR,
        ST_IOW,
        ST_STOP,
        ST_RDRETRY
    } state_e;

    localparam logic [3:0] CMD_IOR = 4'h2;
    localparam logic [3:0] CMD_IOW = 4'h3;
    localparam logic [3:0] CMD_MR  = 4'h6;
    localparam logic [3:0] CMD_MW  = 4'h7;
    localparam logic [3:0] CMD_MRM = 4'hC;
    localparam logic [3:0] CMD_MRL = 4'hE;
    localparam logic [3:0] CMD_MWI = 4'hF;

    localparam int BAR_CNT = 6;
    localparam int BAR_IDW = 3;
    localparam logic [BAR_IDW-1:0] REG_BAR  = 3'd4;
    localparam logic [BAR_IDW-1:0] MEMW_LIM = 3'd4;
endpackage

// File: rtl/tgt_bar_decode.sv
module tgt_bar_decode
    import tgt_pkg::*;
#(
    parameter int AW       = 32,
    parameter int WIN_LOG2 = 12
) (
    input  logic [AW-1:0]         addr,
    input  logic [BAR_CNT*AW-1:0] bases,
    output logic                  hit,
    output logic [BAR_IDW-1:0]    idx
);
    localparam int TW = AW - WIN_LOG2;

    logic [BAR_CNT-1:0] match;

    for (genvar g = 0; g < BAR_CNT; g++) begin : g_cmp
        assign match[g] = (addr[AW-1:WIN_LOG2] == bases[g*AW+WIN_LOG2 +: TW]);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = BAR_CNT - 1; i >= 0; i--) begin
            if (match[i]) idx = BAR_IDW'(i);
        end
    end
endmodule

// File: rtl/tgt_rx_fifo.sv
module tgt_rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         valid,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t   q, d;
    logic   do_push, do_pop;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && (q.cnt != '0);
        if (do_push) d.wr = (q.wr == LASTP) ? '0 : q.wr + 1'b1;
        if (do_pop)  d.rd = (q.rd == LASTP) ? '0 : q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
        if (do_push) mem_q[q.wr] <= wdata;
    end

    assign rdata = mem_q[q.rd];
    assign valid = (q.cnt != '0);
    assign full  = (q.cnt == CW'(DEPTH));
endmodule

// File: rtl/tgt_csr_bank.sv
module tgt_csr_bank #(
    parameter int NREG    = 8,
    parameter int DB0_IDX = 0,
    parameter int DB1_IDX = 1,
    localparam int IW     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    input  logic [3:0]    be,
    input  logic          test_mode,
    output logic [31:0]   rdata,
    output logic          granted
);
    logic [31:0] regs_q [NREG];
    logic [31:0] regs_d [NREG];

    always_comb begin
        regs_d  = regs_q;
        granted = we && (test_mode || idx == IW'(DB0_IDX) || idx == IW'(DB1_IDX));
        if (granted) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) regs_d[idx][8*b +: 8] = wdata[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q[idx];
endmodule

// File: rtl/tgt_wr_ctrl.sv
module tgt_wr_ctrl
    import tgt_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WIN_LOG2   = 12,
    parameter int FIFO_DEPTH = 4,
    parameter int NREG       = 8,
    parameter int DB0_IDX    = 0,
    parameter int DB1_IDX    = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_valid,
    input  logic [AW-1:0]         addr_in,
    input  logic [3:0]            cmd_in,
    input  logic                  data_valid,
    input  logic [31:0]           data_in,
    input  logic [3:0]            data_be,
    input  logic                  data_last,
    input  logic                  test_mode,
    input  logic [BAR_CNT*AW-1:0] bar_bases,
    output logic [1:0]            resp,
    output logic                  rd_req,
    output logic [AW-1:0]         rd_req_addr,
    output logic [BAR_IDW-1:0]    rd_req_bar,
    output logic [31:0]           io_rdata,
    input  logic                  rx_pop,
    output logic                  rx_valid,
    output logic [AW-1:0]         rx_addr,
    output logic [31:0]           rx_data,
    output logic [3:0]            rx_be,
    output logic [BAR_IDW-1:0]    rx_bar
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int EW = AW + 32 + 4 + BAR_IDW;

    typedef struct packed {
        state_e             st;
        logic [AW-1:0]      addr;
        logic [BAR_IDW-1:0] bar;
        logic               first;
        logic               rdreq;
    } ctl_t;

    ctl_t               q, d;
    logic               dec_hit;
    logic [BAR_IDW-1:0] dec_idx;
    logic               push, fifo_full, csr_we, wr_granted;
    logic [IW-1:0]      csr_idx;
    logic [EW-1:0]      rx_entry;
    resp_e              rsp;

    tgt_bar_decode #(.AW(AW), .WIN_LOG2(WIN_LOG2)) u_dec (
        .addr(addr_in), .bases(bar_bases), .hit(dec_hit), .idx(dec_idx)
    );

    always_comb begin
        d       = q;
        d.rdreq = 1'b0;
        rsp     = RSP_NONE;
        push    = 1'b0;
        csr_we  = 1'b0;
        if (addr_valid) begin
            d.addr  = addr_in;
            d.bar   = dec_idx;
            d.first = 1'b1;
            d.st    = ST_IDLE;
            if (dec_hit) begin
                case (cmd_in)
                    CMD_MW, CMD_MWI: if (dec_idx < MEMW_LIM) d.st = ST_MEMW;
                    CMD_IOR:         if (dec_idx == REG_BAR) d.st = ST_IOR;
                    CMD_IOW:         if (dec_idx == REG_BAR) d.st = ST_IOW;
                    CMD_MR, CMD_MRL, CMD_MRM: begin
                        d.st    = ST_RDRETRY;
                        d.rdreq = 1'b1;
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end else if (data_valid) begin
            case (q.st)
                ST_MEMW: begin
                    if (fifo_full) begin
                        rsp  = q.first ? RSP_RETRY : RSP_DISC;
                        d.st = ST_IDLE;
                    end else begin
                        rsp     = RSP_ACCEPT;
                        push    = 1'b1;
                        d.addr  = q.addr + AW'(4);
                        d.first = 1'b0;
                        if (data_last) d.st = ST_IDLE;
                    end
                end
                ST_IOR, ST_IOW: begin
                    rsp    = RSP_ACCEPT;
                    csr_we = (q.st == ST_IOW);
                    d.st   = data_last ? ST_IDLE : ST_STOP;
                end
                ST_STOP: begin
                    rsp  = RSP_DISC;
                    d.st = ST_IDLE;
                end
                ST_RDRETRY: begin
                    rsp  = RSP_RETRY;
                    d.st = ST_IDLE;
                end
                default: rsp = RSP_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, addr: '0, bar: '0, first: 1'b0, rdreq: 1'b0};
        else        q <= d;
    end

    assign csr_idx = q.addr[2 +: IW];

    tgt_rx_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push),
        .wdata({q.addr, data_in, data_be, q.bar}),
        .pop(rx_pop), .rdata(rx_entry), .valid(rx_valid), .full(fifo_full)
    );

    tgt_csr_bank #(.NREG(NREG), .DB0_IDX(DB0_IDX), .DB1_IDX(DB1_IDX)) u_csr (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .idx(csr_idx), .wdata(data_in),
        .be(data_be), .test_mode(test_mode), .rdata(io_rdata), .granted(wr_granted)
    );

    assign resp        = rsp;
    assign rd_req      = q.rdreq;
    assign rd_req_addr = q.addr;
    assign rd_req_bar  = q.bar;
    assign {rx_addr, rx_data, rx_be, rx_bar} = rx_entry;
endmodule

// File: rtl/tgt_wr_ctrl_chk.sv
module tgt_wr_ctrl_chk
    import tgt_pkg::*;
#(
    parameter int NREG    = 8,
    parameter int DB0_IDX = 0,
    parameter int DB1_IDX = 1,
    localparam int IW     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    resp,
    input logic          data_valid,
    input logic          push,
    input logic          fifo_full,
    input logic          csr_we,
    input logic [IW-1:0] csr_idx,
    input logic          test_mode,
    input logic          wr_granted,
    input logic          rx_valid,
    input logic          rx_pop,
    input logic [31:0]   rx_data
);
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !push);

    assert_retry_no_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp == RSP_RETRY) |-> !push);

    assert_resp_in_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp != RSP_NONE) |-> data_valid);

    assert_csr_denied_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !test_mode && csr_idx != IW'(DB0_IDX) && csr_idx != IW'(DB1_IDX))
        |-> !wr_granted);

    assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_pop) |=> (rx_valid && $stable(rx_data)));
endmodule

bind tgt_wr_ctrl tgt_wr_ctrl_chk #(.NREG(NREG), .DB0_IDX(DB0_IDX), .DB1_IDX(DB1_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .resp(resp), .data_valid(data_valid), .push(push),
    .fifo_full(fifo_full), .csr_we(csr_we), .csr_idx(csr_idx), .test_mode(test_mode),
    .wr_granted(wr_granted), .rx_valid(rx_valid), .rx_pop(rx_pop), .rx_data(rx_data)
);

// File: tb/tgt_wr_ctrl_tb.sv
module tgt_wr_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam logic [1:0] R_NONE = 2'b00, R_ACC = 2'b01, R_RTY = 2'b10, R_DSC = 2'b11;
    localparam logic [31:0] B0 = 32'h1000_0000, B1 = 32'h1010_0000, B2 = 32'h1020_0000,
                            B3 = 32'h1030_0000, B4 = 32'h1040_0000, B5 = 32'h1050_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic addr_valid = 0, data_valid = 0, data_last = 0, test_mode = 0, rx_pop = 0;
    logic [31:0] addr_in = 0, data_in = 0;
    logic [3:0] cmd_in = 0, data_be = 0;
    logic [6*AW-1:0] bar_bases;
    logic [1:0] resp;
    logic rd_req, rx_valid;
    logic [31:0] rd_req_addr, io_rdata, rx_addr, rx_data;
    logic [2:0] rd_req_bar, rx_bar;
    logic [3:0] rx_be;
    int vectors = 0, fails = 0;

    assign bar_bases = {B5, B4, B3, B2, B1, B0};

    always #(CLK_PERIOD/2) clk = ~clk;

    tgt_wr_ctrl #(.AW(AW), .WIN_LOG2(12), .FIFO_DEPTH(4), .NREG(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_in(addr_in),
        .cmd_in(cmd_in), .data_valid(data_valid), .data_in(data_in), .data_be(data_be),
        .data_last(data_last), .test_mode(test_mode), .bar_bases(bar_bases),
        .resp(resp), .rd_req(rd_req), .rd_req_addr(rd_req_addr), .rd_req_bar(rd_req_bar),
        .io_rdata(io_rdata), .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_addr(rx_addr),
        .rx_data(rx_data), .rx_be(rx_be), .rx_bar(rx_bar)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        addr_valid = 0; data_valid = 0; data_last = 0; #1;
    endtask

    task automatic aphase(input logic [31:0] a, input logic [3:0] c);
        @(negedge clk);
        addr_valid = 1; addr_in = a; cmd_in = c; data_valid = 0; data_last = 0; #1;
    endtask

    task automatic dphase(input logic [31:0] d, input logic [3:0] be, input logic last,
                          input logic [1:0] exp_rsp, input string tag);
        @(negedge clk);
        addr_valid = 0; data_valid = 1; data_in = d; data_be = be; data_last = last; #1;
        check(tag, {30'd0, resp}, {30'd0, exp_rsp});
    endtask

    task automatic pop_check(input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] be, input logic [2:0] bar, input string tag);
        @(negedge clk); #1;
        check({tag, " valid"}, {31'd0, rx_valid}, 32'd1);
        check({tag, " addr"}, rx_addr, a);
        check({tag, " data"}, rx_data, d);
        check({tag, " be"}, {28'd0, rx_be}, {28'd0, be});
        check({tag, " bar"}, {29'd0, rx_bar}, {29'd0, bar});
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic t_reset();
        #1;
        check("R2 reset rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R9 reset resp", {30'd0, resp}, 32'd0);
        check("R8 reset rd_req", {31'd0, rd_req}, 32'd0);
        check("R7 reset io_rdata", io_rdata, 32'd0);
    endtask

    task automatic t_burst();
        aphase(B2 + 32'h10, 4'h7);
        dphase(32'hA1A1_0001, 4'b0101, 0, R_ACC, "R1 burst p1");
        dphase(32'hA1A1_0002, 4'b1010, 0, R_ACC, "R1 burst p2");
        dphase(32'hA1A1_0003, 4'b0000, 1, R_ACC, "R5 burst p3 be0");
        idle();
        aphase(B0 + 32'h40, 4'hF);
        dphase(32'h0BAD_F00D, 4'b1111, 1, R_ACC, "R1 mwi");
        idle();
        pop_check(B2 + 32'h10, 32'hA1A1_0001, 4'b0101, 3'd2, "R2 e0");
        pop_check(B2 + 32'h14, 32'hA1A1_0002, 4'b1010, 3'd2, "R2 e1");
        pop_check(B2 + 32'h18, 32'hA1A1_0003, 4'b0000, 3'd2, "R5 e2");
        pop_check(B0 + 32'h40, 32'h0BAD_F00D, 4'b1111, 3'd0, "R2 e3");
        #1 check("R2 drained", {31'd0, rx_valid}, 32'd0);
    endtask

    task automatic t_flow();
        aphase(B1, 4'h7);
        for (int i = 0; i < 4; i++)
            dphase(32'hC0 + i, 4'hF, 0, R_ACC, "R4 fill");
        dphase(32'hC4, 4'hF, 0, R_DSC, "R4 disconnect when full");
        dphase(32'hC5, 4'hF, 1, R_NONE, "R4 after disconnect");
        idle();
        aphase(B1 + 32'h100, 4'h7);
        dphase(32'hEE, 4'hF, 1, R_RTY, "R3 retry full");
        idle();
        for (int i = 0; i < 4; i++)
            pop_check(B1 + 32'(4*i), 32'hC0 + i, 4'hF, 3'd1, "R3 kept");
        #1 check("R3 no extra entry", {31'd0, rx_valid}, 32'd0);
    endtask

    task automatic t_io();
        test_mode = 0;
        aphase(B4 + 32'h8, 4'h3);
        dphase(32'h0000_AAAA, 4'hF, 1, R_ACC, "R6 iow accept");
        aphase(B4 + 32'h8, 4'h2);
        dphase(32'h0, 4'hF, 1, R_ACC, "R6 ior accept");
        check("R7 denied write dropped", io_rdata, 32'h0);
        aphase(B4 + 32'h4, 4'h3);
        dphase(32'h1234_5678, 4'b0011, 1, R_ACC, "R7 doorbell write");
        aphase(B4 + 32'h4, 4'h2);
        dphase(32'h0, 4'hF, 1, R_ACC, "R7 doorbell read");
        check("R7 doorbell value", io_rdata, 32'h0000_5678);
        test_mode = 1;
        aphase(B4 + 32'h8, 4'h3);
        dphase(32'hDEAD_BEEF, 4'hF, 1, R_ACC, "R7 test write");
        aphase(B4 + 32'h8, 4'h2);
        dphase(32'h0, 4'hF, 1, R_ACC, "R7 test read");
        check("R7 test value", io_rdata, 32'hDEAD_BEEF);
        test_mode = 0;
        aphase(B4, 4'h3);
        dphase(32'h0000_0011, 4'hF, 0, R_ACC, "R6 io p1");
        dphase(32'h0000_0022, 4'hF, 0, R_DSC, "R6 io p2 disconnect");
        aphase(B4, 4'h2);
        dphase(32'h0, 4'hF, 1, R_ACC, "R6 io readback");
        check("R6 only first phase written", io_rdata, 32'h0000_0011);
        idle();
    endtask

    task automatic t_read();
        aphase(B3 + 32'h40, 4'h6);
        dphase(32'h0, 4'hF, 1, R_RTY, "R8 read retried");
        check("R8 rd_req", {31'd0, rd_req}, 32'd1);
        check("R8 rd_req_addr", rd_req_addr, B3 + 32'h40);
        check("R8 rd_req_bar", {29'd0, rd_req_bar}, 32'd3);
        idle();
        check("R8 rd_req one cycle", {31'd0, rd_req}, 32'd0);
    endtask

    task automatic t_miss();
        aphase(32'h2000_0000, 4'h7);
        dphase(32'h1, 4'hF, 1, R_NONE, "R9 no hit");
        aphase(B5, 4'h7);
        dphase(32'h2, 4'hF, 1, R_NONE, "R1 bar5 write");
        aphase(B0, 4'h1);
        dphase(32'h3, 4'hF, 1, R_NONE, "R9 bad cmd");
        aphase(B1, 4'h3);
        dphase(32'h4, 4'hF, 1, R_NONE, "R9 io off bar4");
        idle();
        check("R9 nothing pushed", {31'd0, rx_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_burst();
        t_flow();
        t_io();
        t_read();
        t_miss();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule